// File: doc/BRIEF.md
# Button Sequence Combination Lock

This block is a clocked state machine that guards a fixed four-step combination entered on four buttons. On every rising clock edge it takes one 2-bit button code and moves one step along the code or falls back. The lock opens only when the buttons arrive in the order KEY3, KEY1, KEY2, KEY0, one per clock.

A wrong button sends the machine back to idle. KEY3 at any point restarts progress at the first step, so a fresh entry can begin at once, even straight out of the open state. The current step is visible on a 3-bit state output. A single open flag is decoded from that state alone, so it behaves as a Moore output and never depends on the button present in the same cycle.

Top module: `seq_lock`

## Requirements
- R1: Button codes are KEY0=0, KEY1=1, KEY2=2, KEY3=3 on `btn_i`. State codes on `state_o` are IDLE=0, GOT1=1, GOT2=2, GOT3=3, OPEN=4.
- R2: While `rst_i` is high at a rising clock edge, the next state is IDLE and `unlock_o` is low, whatever button is present.
- R3: In IDLE, KEY3 moves to GOT1. KEY0, KEY1 and KEY2 hold IDLE.
- R4: In GOT1, KEY1 moves to GOT2 and KEY3 holds GOT1. KEY0 and KEY2 return to IDLE.
- R5: In GOT2, KEY2 moves to GOT3 and KEY3 moves to GOT1. KEY0 and KEY1 return to IDLE.
- R6: In GOT3, KEY0 moves to OPEN and KEY3 moves to GOT1. KEY1 and KEY2 return to IDLE.
- R7: In OPEN, KEY3 moves to GOT1. Every other button returns to IDLE.
- R8: `unlock_o` is high exactly in the cycles where `state_o` is OPEN (4).
- R9: After reset `state_o` only takes values 0 to 4. Any unused code (5 to 7) would go to IDLE on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock; one button is sampled per edge |
| rst_i | input | 1 | Synchronous active-high reset to IDLE |
| btn_i | input | 2 | Button code (KEY0..KEY3 = 0..3) |
| state_o | output | 3 | Current step of the lock (IDLE..OPEN = 0..4) |
| unlock_o | output | 1 | High while the lock is open |

## Verification
Two things can land on the same edge here, and the bench provokes both. In the first case, reset is raised while the machine sits in GOT3 with KEY0 on the input, so completing the code and resetting collide. The bench expects IDLE with the lock still shut. In the second case, KEY3 arrives while the lock is OPEN, so dropping the open flag and starting a new entry happen together. The bench expects GOT1 with `unlock_o` low in that same cycle, followed by a second full entry that opens again. Random traffic biased toward the correct next key hits both collisions repeatedly, and every edge is judged against a reference step function written in the bench.

// File: rtl/seq_lock_pkg.sv
package seq_lock_pkg;
  parameter int BTN_W   = 2;
  parameter int STATE_W = 3;

  typedef enum logic [BTN_W-1:0] {
    KEY0 = 2'd0,
    KEY1 = 2'd1,
    KEY2 = 2'd2,
    KEY3 = 2'd3
  } lock_btn_e;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 3'd0,
    ST_GOT1 = 3'd1,
    ST_GOT2 = 3'd2,
    ST_GOT3 = 3'd3,
    ST_OPEN = 3'd4
  } lock_state_e;

  // Button expected to advance from a given step (unused in OPEN)
  function automatic lock_btn_e lock_want(input lock_state_e cur);
    case (cur)
      ST_IDLE: lock_want = KEY3;
      ST_GOT1: lock_want = KEY1;
      ST_GOT2: lock_want = KEY2;
      ST_GOT3: lock_want = KEY0;
      default: lock_want = KEY3;
    endcase
  endfunction

  function automatic logic lock_legal(input logic [STATE_W-1:0] s);
    lock_legal = (s <= ST_OPEN);
  endfunction

  // Full step rule: restart on KEY3, advance on the wanted key,
  // otherwise fall back to idle; unused codes fall back to idle.
  function automatic lock_state_e lock_step(input lock_state_e cur,
                                            input lock_btn_e   b);
    if (!lock_legal(cur)) begin
      lock_step = ST_IDLE;
    end else if (b == KEY3) begin
      lock_step = ST_GOT1;
    end else if (cur != ST_OPEN && b == lock_want(cur)) begin
      lock_step = lock_state_e'(cur + 3'd1);
    end else begin
      lock_step = ST_IDLE;
    end
  endfunction
endpackage

// File: rtl/seq_lock_next.sv
module seq_lock_next
  import seq_lock_pkg::*;
(
  input  lock_state_e cur_i,
  input  lock_btn_e   btn_i,
  output lock_state_e nxt_o,
  output logic        restart_o,
  output logic        advance_o
);
  logic legal;

  always_comb begin
    legal     = lock_legal(cur_i);
    restart_o = legal && (btn_i == KEY3);
    advance_o = legal && !restart_o && (cur_i != ST_OPEN) &&
                (btn_i == lock_want(cur_i));
    nxt_o     = lock_step(cur_i, btn_i);
  end
endmodule

// File: rtl/seq_lock_reg.sv
module seq_lock_reg
  import seq_lock_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_i,
  input  lock_state_e nxt_i,
  output lock_state_e cur_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) cur_o <= ST_IDLE;
    else       cur_o <= nxt_i;
  end
endmodule

// File: rtl/seq_lock_decode.sv
module seq_lock_decode
  import seq_lock_pkg::*;
(
  input  lock_state_e cur_i,
  output logic        open_o
);
  assign open_o = (cur_i == ST_OPEN);
endmodule

// File: rtl/seq_lock.sv
module seq_lock
  import seq_lock_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [BTN_W-1:0]   btn_i,
  output logic [STATE_W-1:0] state_o,
  output logic               unlock_o
);
  lock_btn_e   btn;
  lock_state_e cur_q;
  lock_state_e nxt;
  logic        restart_hit;
  logic        advance_hit;

  assign btn = lock_btn_e'(btn_i);

  seq_lock_next u_next (
    .cur_i     (cur_q),
    .btn_i     (btn),
    .nxt_o     (nxt),
    .restart_o (restart_hit),
    .advance_o (advance_hit)
  );

  seq_lock_reg u_reg (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .nxt_i (nxt),
    .cur_o (cur_q)
  );

  seq_lock_decode u_dec (
    .cur_i  (cur_q),
    .open_o (unlock_o)
  );

  assign state_o = cur_q;
endmodule

// File: rtl/seq_lock_chk.sv
module seq_lock_chk
  import seq_lock_pkg::*;
(
  input logic               clk_i,
  input logic               rst_i,
  input logic [BTN_W-1:0]   btn_i,
  input logic [STATE_W-1:0] state_o,
  input logic               unlock_o,
  input logic               restart_hit,
  input logic               advance_hit
);
  // R2: reset wins over any button
  p_reset_idle_r2: assert property (@(posedge clk_i)
    rst_i |=> (state_o == 3'd0 && !unlock_o));

  // R3..R7: KEY3 from any legal step lands on GOT1
  p_restart_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    restart_hit |=> (state_o == 3'd1));

  // R3..R6: an advancing key moves exactly one step up
  p_advance_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    advance_hit |=> (state_o == $past(state_o) + 3'd1));

  // R4: wrong key in GOT1 drops to idle
  p_got1_wrong_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_o == 3'd1 && (btn_i == 2'd0 || btn_i == 2'd2)) |=> (state_o == 3'd0));

  // R6: final key opens the lock
  p_open_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_o == 3'd3 && btn_i == 2'd0) |=> unlock_o);

  // R8: open flag tracks the open state
  p_unlock_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    unlock_o == (state_o == 3'd4));

  // R9: no unused code after reset
  p_legal_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    state_o <= 3'd4);
endmodule

bind seq_lock seq_lock_chk u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .btn_i       (btn_i),
  .state_o     (state_o),
  .unlock_o    (unlock_o),
  .restart_hit (restart_hit),
  .advance_hit (advance_hit)
);

// File: tb/seq_lock_tb.sv
`timescale 1ns/1ps
module seq_lock_tb;
  logic       clk_i = 1'b0;
  logic       rst_i = 1'b1;
  logic [1:0] btn_i = 2'd0;
  logic [2:0] state_o;
  logic       unlock_o;

  int checks   = 0;
  int failures = 0;
  int exp_st   = 0;
  bit done     = 1'b0;

  always #2.5 clk_i = ~clk_i;

  seq_lock u_dut (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .btn_i    (btn_i),
    .state_o  (state_o),
    .unlock_o (unlock_o)
  );

  // Reference: the code as a list, position = progress count
  function automatic int code_at(input int pos);
    case (pos)
      0: return 3;
      1: return 1;
      2: return 2;
      default: return 0;
    endcase
  endfunction

  function automatic int ref_next(input int s, input int b);
    if (b == 3) return 1;
    if (s < 4 && s > 0 && b == code_at(s)) return s + 1;
    return 0;
  endfunction

  function automatic string tag_for(input int s, input bit r);
    if (r) return "R2";
    case (s)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int b, input bit r);
    int prev;
    @(negedge clk_i);
    btn_i = b[1:0];
    rst_i = r;
    prev  = exp_st;
    @(posedge clk_i);
    #1;
    exp_st = r ? 0 : ref_next(prev, b);
    check(tag_for(prev, r), int'(state_o), exp_st);
    check("R8", int'(unlock_o), (exp_st == 4) ? 1 : 0);
    checks++;
    if (state_o > 3'd4) begin
      failures++;
      $display("FAIL R9 actual=%0d expected=<=4", state_o);
    end
  endtask

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    // R2 reset state
    step(0, 1);
    step(3, 1);
    check("R2 reset", int'(state_o), 0);
    // R1/R3..R6 full code opens
    step(0, 0); step(1, 0); step(2, 0);
    step(3, 0); step(1, 0); step(2, 0); step(0, 0);
    check("R6 opened", int'(unlock_o), 1);
    // R7 KEY3 in OPEN restarts, then second entry
    step(3, 0);
    check("R7 restart", int'(state_o), 1);
    step(1, 0); step(2, 0); step(0, 0);
    check("R8 reopen", int'(unlock_o), 1);
    step(1, 0);   // R7 non-KEY3 leaves OPEN
    // R4 KEY3 holds GOT1
    step(3, 0); step(3, 0); step(3, 0);
    // R4/R5/R6 wrong keys
    step(2, 0);
    step(3, 0); step(1, 0); step(1, 0);
    step(3, 0); step(1, 0); step(2, 0); step(2, 0);
    step(3, 0); step(1, 0); step(3, 0); step(1, 0); step(2, 0); step(3, 0);
    // R2 reset collides with final key
    step(1, 0); step(2, 0);
    step(0, 1);
    check("R2 reset wins", int'(unlock_o), 0);
    // random, biased toward the right next key
    for (int i = 0; i < 4000; i++) begin
      int b;
      bit r;
      r = ($urandom % 64) == 0;
      if (($urandom % 2) == 0 && exp_st < 4) b = code_at(exp_st);
      else b = $urandom % 4;
      step(b, r);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule